// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block sits at the front of a Reed-Solomon decoder for 31-symbol codewords over GF(2^5). It takes in one 5-bit symbol per valid cycle, highest-degree coefficient first. A start pulse travels with the first symbol of each codeword. While the codeword arrives, four accumulators evaluate the received polynomial at alpha, alpha^2, alpha^3 and alpha^4 in parallel.

After the 31st symbol, the four syndromes appear on one packed output bus. One of two flags then reports the result. The no-error flag means every syndrome is zero, so decoding can stop. The ready flag means at least one syndrome is nonzero, so the error-locator stage should take over.

Every accepted symbol is also copied onto a registered forwarding bus, so a codeword store elsewhere in the decoder can capture it.

Top module: `rs_syndrome_calc`

## Requirements
- R1: While reset is held, and after it is released with no symbols accepted, both flags are low, the syndrome bus is zero and the forwarding valid is low.
- R2: The field is GF(2^5) built on x^5+x^2+1. A symbol's value encodes the polynomial basis: bit k is the coefficient of alpha^k, so alpha is 5'b00010. The 31 symbols r0..r30 arrive in that order. Each syndrome is Sk = sum over j of r_j * alpha^(k*(30-j)) for k = 1 to 4.
- R3: A cycle with both valid and start high discards any earlier accumulation, whether or not that codeword was complete. It drops both flags on the next cycle and takes its symbol as r0.
- R4: The syndromes and the flags are updated on the clock edge that accepts the 31st symbol, so they are visible in the following cycle.
- R5: The no-error flag rises only when all four syndromes are zero, and the syndrome bus is then all zero.
- R6: The ready flag rises only when at least one syndrome is nonzero. The two flags are never high together.
- R7: Once a codeword is complete, the flags and syndromes hold until the next start. Valid symbols without a start change neither the syndromes nor the flags, and they are not forwarded.
- R8: Cycles with valid low may fall anywhere between the symbols of a codeword and do not change the result.
- R9: Each accepted symbol appears on the forwarding bus one cycle later, with the forwarding valid high. The forwarding valid is low in every cycle that follows a cycle with no accepted symbol.
- R10: Syndrome k sits in bits [5k-1:5(k-1)] of the syndrome bus, so S1 occupies bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid | input | 1 | A symbol is present on sym_in |
| sym_start | input | 1 | The present symbol is the first of a codeword |
| sym_in | input | 5 | Received symbol |
| fwd_valid | output | 1 | Forwarded symbol is valid |
| fwd_sym | output | 5 | Accepted symbol, delayed one cycle |
| syndromes | output | 20 | S4..S1 packed, S1 in the low bits |
| no_err | output | 1 | All syndromes zero; held until next start |
| syn_ready | output | 1 | Some syndrome nonzero; held until next start |

## Verification
Every syndrome is compared against a power-sum reference over the same field, which shares nothing with the Horner update in the design.

Valid codewords come from a systematic encoder in the bench. The information patterns are all zeros, all 31s, a rising ramp, an alternating pattern and random data. These must raise the no-error flag, which separates a correct field and exponent choice from a wrong one.

The same codewords are also sent with one or two corrupted symbols, placed in the first, a middle or a parity position. These must raise the ready flag with the exact syndromes, which exposes errors in symbol ordering and in the per-syndrome power.

Further runs cover an aborted partial codeword followed by a restart, stalls between symbols, and stray symbols after completion. These separate clearing, hold and ignore behaviour.

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc #(
  parameter int SYM_W = 5,
  parameter int N_SYM = 31,
  parameter int NSYN  = 4,
  parameter logic [SYM_W-1:0] POLY = 5'b00101
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sym_valid,
  input  logic                  sym_start,
  input  logic [SYM_W-1:0]      sym_in,
  output logic                  fwd_valid,
  output logic [SYM_W-1:0]      fwd_sym,
  output logic [NSYN*SYM_W-1:0] syndromes,
  output logic                  no_err,
  output logic                  syn_ready
);
  localparam int CNT_W = $clog2(N_SYM + 1);

  function automatic logic [SYM_W-1:0] mul_alpha(input logic [SYM_W-1:0] x);
    return {x[SYM_W-2:0], 1'b0} ^ (x[SYM_W-1] ? POLY : '0);
  endfunction

  function automatic logic [SYM_W-1:0] mul_alpha_pow(input logic [SYM_W-1:0] x, input int k);
    logic [SYM_W-1:0] r;
    r = x;
    for (int n = 0; n < NSYN; n++)
      if (n < k) r = mul_alpha(r);
    return r;
  endfunction

  logic [CNT_W-1:0]      cnt;
  logic                  busy;
  logic [NSYN*SYM_W-1:0] nxt;

  wire accept = sym_valid && (sym_start || busy);
  wire last   = accept && (sym_start ? (N_SYM == 1) : (cnt == CNT_W'(N_SYM - 1)));

  for (genvar i = 0; i < NSYN; i++) begin : g_acc
    wire [SYM_W-1:0] cur = syndromes[i*SYM_W +: SYM_W];
    assign nxt[i*SYM_W +: SYM_W] = sym_start ? sym_in : (mul_alpha_pow(cur, i + 1) ^ sym_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      busy      <= 1'b0;
      syndromes <= '0;
      no_err    <= 1'b0;
      syn_ready <= 1'b0;
    end else if (accept) begin
      syndromes <= nxt;
      cnt       <= sym_start ? CNT_W'(1) : cnt + CNT_W'(1);
      busy      <= !last;
      if (last) begin
        no_err    <= (nxt == '0);
        syn_ready <= (nxt != '0);
      end else if (sym_start) begin
        no_err    <= 1'b0;
        syn_ready <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_sym   <= '0;
    end else begin
      fwd_valid <= accept;
      if (accept) fwd_sym <= sym_in;
    end
  end
endmodule

module rs_syndrome_calc_chk #(
  parameter int SYM_W = 5,
  parameter int NSYN  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sym_valid,
  input logic                  sym_start,
  input logic [SYM_W-1:0]      sym_in,
  input logic                  fwd_valid,
  input logic [SYM_W-1:0]      fwd_sym,
  input logic [NSYN*SYM_W-1:0] syndromes,
  input logic                  no_err,
  input logic                  syn_ready
);
  // R6
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n) !(no_err && syn_ready));
  // R5
  noerr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) no_err |-> syndromes == '0);
  // R6
  rdy_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) syn_ready |-> syndromes != '0);
  // R7
  hold_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_err || syn_ready) && !(sym_valid && sym_start) |=> $stable(no_err) && $stable(syn_ready) && $stable(syndromes));
  // R7
  stray_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_err || syn_ready) && sym_valid && !sym_start |=> !fwd_valid);
  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_start |=> !no_err && !syn_ready);
  // R9
  fwd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_start |=> fwd_valid && fwd_sym == $past(sym_in));
  // R9
  fwd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !sym_valid |=> !fwd_valid);
endmodule

bind rs_syndrome_calc rs_syndrome_calc_chk #(.SYM_W(SYM_W), .NSYN(NSYN)) u_chk (.*);

// File: tb/sim_rs_syndrome_calc.sv
`timescale 1ns/1ps
module sim_rs_syndrome_calc;
  logic clk = 0, rst_n = 0, sym_valid = 0, sym_start = 0;
  logic [4:0] sym_in = '0;
  logic fwd_valid, no_err, syn_ready;
  logic [4:0] fwd_sym;
  logic [19:0] syndromes;

  rs_syndrome_calc u0 (.*);
  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [4:0] cw [31];
  logic [4:0] g [5];
  logic [20:0] exp_q [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [4:0] gmul(input logic [4:0] a, input logic [4:0] b);
    logic [9:0] p = '0;
    for (int i = 0; i < 5; i++) if (b[i]) p ^= 10'(a) << i;
    for (int i = 9; i >= 5; i--) if (p[i]) p ^= 10'b100101 << (i - 5);
    return p[4:0];
  endfunction

  function automatic logic [4:0] apow(input int e);
    logic [4:0] r = 5'd1;
    for (int i = 0; i < e % 31; i++) r = gmul(r, 5'd2);
    return r;
  endfunction

  function automatic logic [19:0] ref_synd();
    logic [19:0] s = '0;
    for (int k = 1; k <= 4; k++)
      for (int j = 0; j < 31; j++) s[(k-1)*5 +: 5] ^= gmul(cw[j], apow(k * (30 - j)));
    return s;
  endfunction

  task automatic build_gen();
    g[0] = 5'd1; for (int k = 1; k < 5; k++) g[k] = '0;
    for (int i = 1; i <= 4; i++)
      for (int k = 4; k >= 0; k--) g[k] = (k > 0 ? g[k-1] : 5'd0) ^ gmul(g[k], apow(i));
  endtask

  task automatic encode();
    logic [4:0] p [4];
    logic [4:0] fb;
    for (int k = 0; k < 4; k++) p[k] = '0;
    for (int j = 0; j < 27; j++) begin
      fb = cw[j] ^ p[3];
      p[3] = p[2] ^ gmul(fb, g[3]);
      p[2] = p[1] ^ gmul(fb, g[2]);
      p[1] = p[0] ^ gmul(fb, g[1]);
      p[0] = gmul(fb, g[0]);
    end
    for (int k = 0; k < 4; k++) cw[27 + k] = p[3 - k];
  endtask

  task automatic drive_cw(input int gap, input int nsym);
    int bad = 0;
    logic [19:0] s;
    if (nsym == 31) begin s = ref_synd(); exp_q.push_back({(s == '0), s}); end
    for (int j = 0; j < nsym; j++) begin
      sym_valid = 1; sym_start = (j == 0); sym_in = cw[j];
      @(negedge clk);
      if (!fwd_valid || fwd_sym !== cw[j]) bad++;
      sym_valid = 0; sym_start = 0;
      for (int q = 0; q < gap; q++) begin @(negedge clk); if (fwd_valid) bad++; end
    end
    check(bad == 0, "R9 forwarding", bad, 0);
  endtask

  // Monitor: on every flag rise, compare with the next expected item (R2 R4 R5 R6 R10)
  logic prev_done = 0;
  always @(negedge clk) begin
    logic [20:0] e;
    if (rst_n && (no_err || syn_ready) && !prev_done) begin
      if (exp_q.size() == 0) check(0, "R4 unexpected result", 32'(syndromes), 0);
      else begin
        e = exp_q.pop_front();
        check(syndromes == e[19:0], "R2 R10 syndromes", 32'(syndromes), 32'(e[19:0]));
        check(no_err == e[20] && syn_ready == !e[20], "R5 R6 flags", {no_err, syn_ready}, {e[20], !e[20]});
      end
    end
    prev_done <= rst_n && (no_err || syn_ready);
  end

  task automatic fill(input int kind);
    for (int j = 0; j < 27; j++)
      case (kind)
        0: cw[j] = 5'd0;
        1: cw[j] = 5'd31;
        2: cw[j] = 5'(j + 1);
        3: cw[j] = j[0] ? 5'd10 : 5'd21;
        default: cw[j] = 5'($urandom_range(0, 31));
      endcase
    encode();
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    check(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    logic [19:0] hs;
    logic hn, hr;
    build_gen();
    repeat (3) @(negedge clk);
    check(!no_err && !syn_ready && syndromes == 0 && !fwd_valid, "R1 reset", {no_err, syn_ready, fwd_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!no_err && !syn_ready && syndromes == 0 && !fwd_valid, "R1 after release", 32'(syndromes), 0);

    for (int kind = 0; kind < 5; kind++) begin fill(kind); drive_cw(0, 31); @(negedge clk); end
    fill(2); cw[0] ^= 5'd7; drive_cw(0, 31); @(negedge clk);
    fill(3); cw[30] ^= 5'd1; drive_cw(0, 31); @(negedge clk);
    fill(4); cw[13] ^= 5'd19; cw[28] ^= 5'd4; drive_cw(0, 31); @(negedge clk);

    // R8 stalls
    fill(1); cw[5] ^= 5'd3; drive_cw(2, 31); @(negedge clk);
    fill(4); drive_cw(1, 31); @(negedge clk);

    // R3 aborted partial codeword, then full restart
    fill(1); drive_cw(0, 12);
    check(!no_err && !syn_ready, "R3 flags low mid-block", {no_err, syn_ready}, 0);
    fill(2); cw[20] ^= 5'd9; drive_cw(0, 31); @(negedge clk);

    // R7 stray symbols after completion
    hs = syndromes; hn = no_err; hr = syn_ready;
    for (int j = 0; j < 5; j++) begin
      sym_valid = 1; sym_in = 5'(j + 3);
      @(negedge clk);
      check(!fwd_valid, "R7 stray not forwarded", fwd_valid, 0);
    end
    sym_valid = 0;
    @(negedge clk);
    check(syndromes == hs && no_err == hn && syn_ready == hr, "R7 hold", 32'(syndromes), 32'(hs));

    for (int r = 0; r < 20; r++) begin
      fill(4);
      if (r % 2) cw[$urandom_range(0, 30)] ^= 5'($urandom_range(1, 31));
      drive_cw(r % 3, 31); @(negedge clk);
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
    finish_up();
  end
endmodule